// File: doc/BRIEF.md
# Static-Sample Auto-Mute Detector

This block watches a two-channel stream of signed audio words. Each channel delivers one word per frame and marks it with its own valid strobe. When a channel carries nothing but digital silence for a long unbroken run, the block raises a mute request for that channel. Digital silence is a word of all zeros or a word of all ones (minus one). The request drops again on the first word that is not silent.

The two mute requests go to a separate level-change controller. That controller applies them with the same gradual ramp or zero-crossing step it uses for volume changes, so the mute takes hold smoothly rather than as a hard cut. A single enable input switches the whole feature. While the enable is low, both run counts and both requests are held cleared. The run length and the sample width are parameters. By default the run length is 512 samples and the width is 24 bits.

Top module: `silence_mute_det`

## Requirements
- R1: After reset both mute requests (`muteReqL`, `muteReqR`) are 0.
- R2: A sample counts as silent only when all `SAMPLE_W` bits are 0 or all are 1. Any other value, such as 1, -2, the most negative or most positive value, or a word with a single bit set, counts as non-silent.
- R3: With the enable high, a channel's mute request rises in the clock cycle after the edge that accepts its `RUN_LEN`-th consecutive silent valid sample. It is still 0 after `RUN_LEN`-1 such samples.
- R4: A non-silent valid sample on a channel drops that channel's request at the next edge and restarts its count, so a fresh run of `RUN_LEN` silent samples is needed to mute again.
- R5: Counting and muting for the left and right channels are independent. Traffic on one channel never changes the other channel's request.
- R6: While `muteEnable` is 0 no request asserts. Driving it low clears both counts and both requests at the next edge.
- R7: The run count saturates at `RUN_LEN`. An arbitrarily long silence keeps the request asserted and never wraps it back to 0.
- R8: A count advances only on a cycle where that channel's valid strobe is high. Idle cycles neither advance the count nor reset it.
- R9: Zero words and all-ones words may be mixed freely inside one run, and the mix still counts as one silent run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| muteEnable | input | 1 | Feature enable, 0 after reset by system convention |
| sampleValidL | input | 1 | Left sample strobe |
| sampleL | input | SAMPLE_W | Left sample, two's complement |
| sampleValidR | input | 1 | Right sample strobe |
| sampleR | input | SAMPLE_W | Right sample, two's complement |
| muteReqL | output | 1 | Left mute request to the level-change controller |
| muteReqR | output | 1 | Right mute request to the level-change controller |

## Verification
Several functions can land on the same edge, and the two pairings that matter most are these. A channel's count can reach its limit on the same edge that the enable falls. A non-silent word can arrive on one channel on the same edge that the other channel completes its run. The bench provokes both by driving the strobes and the enable together in a single cycle. It judges each case against an arithmetic per-channel run model in which the clear wins and the channels never interact. The bound checker watches the same pairs on every cycle.

// File: rtl/silence_mute_pkg.sv
package silence_mute_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_L = 0;
  localparam int CH_R = 1;

  typedef struct packed {
    logic              clearAll;
    logic [NUM_CH-1:0] advance;
    logic [NUM_CH-1:0] restart;
  } muteStrobes_t;
endpackage

// File: rtl/silence_mute_ctrl.sv
module silence_mute_ctrl
  import silence_mute_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                          muteEnable,
  input  logic [NUM_CH-1:0]             sampleValid,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0] sampleIn,
  output muteStrobes_t                  strobes
);
  logic [NUM_CH-1:0] isSilent;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_classify
    assign isSilent[ch] = (sampleIn[ch] == '0) || (sampleIn[ch] == '1);
  end

  always_comb begin
    strobes.clearAll = !muteEnable;
    strobes.advance  = {NUM_CH{muteEnable}} & sampleValid & isSilent;
    strobes.restart  = {NUM_CH{muteEnable}} & sampleValid & ~isSilent;
  end
endmodule

// File: rtl/silence_mute_dp.sv
module silence_mute_dp
  import silence_mute_pkg::*;
#(
  parameter int RUN_LEN = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  muteStrobes_t      strobes,
  output logic [NUM_CH-1:0] muteFlag
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(RUN_LEN - 1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] runCount;
    always_ff @(posedge clk) begin
      if (!rstN || strobes.clearAll || strobes.restart[ch]) begin
        runCount     <= '0;
        muteFlag[ch] <= 1'b0;
      end else if (strobes.advance[ch] && runCount != LIMIT) begin
        runCount <= runCount + 1'b1;
        if (runCount == LAST) muteFlag[ch] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/silence_mute_det.sv
module silence_mute_det
  import silence_mute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 512
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                muteEnable,
  input  logic                sampleValidL,
  input  logic [SAMPLE_W-1:0] sampleL,
  input  logic                sampleValidR,
  input  logic [SAMPLE_W-1:0] sampleR,
  output logic                muteReqL,
  output logic                muteReqR
);
  muteStrobes_t strobes;
  logic [NUM_CH-1:0] muteFlag;
  logic [NUM_CH-1:0] validVec;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] sampleVec;

  assign validVec[CH_L]  = sampleValidL;
  assign validVec[CH_R]  = sampleValidR;
  assign sampleVec[CH_L] = sampleL;
  assign sampleVec[CH_R] = sampleR;

  silence_mute_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
    .muteEnable (muteEnable),
    .sampleValid(validVec),
    .sampleIn   (sampleVec),
    .strobes    (strobes)
  );

  silence_mute_dp #(.RUN_LEN(RUN_LEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .muteFlag(muteFlag)
  );

  assign muteReqL = muteFlag[CH_L];
  assign muteReqR = muteFlag[CH_R];
endmodule

// File: rtl/silence_mute_chk.sv
module silence_mute_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                muteEnable,
  input logic                sampleValidL,
  input logic [SAMPLE_W-1:0] sampleL,
  input logic                sampleValidR,
  input logic [SAMPLE_W-1:0] sampleR,
  input logic                muteReqL,
  input logic                muteReqR
);
  logic silentL, silentR;
  assign silentL = (sampleL == '0) || (sampleL == '1);
  assign silentR = (sampleR == '0) || (sampleR == '1);

  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    !muteEnable |=> (!muteReqL && !muteReqR));

  assert_release_left_R4: assert property (@(posedge clk) disable iff (!rstN)
    (muteEnable && sampleValidL && !silentL) |=> !muteReqL);

  assert_release_right_R4: assert property (@(posedge clk) disable iff (!rstN)
    (muteEnable && sampleValidR && !silentR) |=> !muteReqR);

  assert_rise_on_silence_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muteReqL) |-> $past(muteEnable && sampleValidL && silentL));

  assert_rise_right_indep_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muteReqR) |-> $past(muteEnable && sampleValidR && silentR));

  assert_idle_holds_left_R8: assert property (@(posedge clk) disable iff (!rstN)
    (muteEnable && !sampleValidL) |=> $stable(muteReqL));

  assert_idle_holds_right_R8: assert property (@(posedge clk) disable iff (!rstN)
    (muteEnable && !sampleValidR) |=> $stable(muteReqR));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (muteReqL && muteEnable && sampleValidL && silentL) |=> muteReqL);
endmodule

bind silence_mute_det silence_mute_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rstN(rstN), .muteEnable(muteEnable),
  .sampleValidL(sampleValidL), .sampleL(sampleL),
  .sampleValidR(sampleValidR), .sampleR(sampleR),
  .muteReqL(muteReqL), .muteReqR(muteReqR)
);

// File: tb/sim_silence_mute_det.sv
`timescale 1ns/1ps
module sim_silence_mute_det;
  localparam int W = 24;
  localparam int RL = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic muteEnable = 1'b0;
  logic sampleValidL = 1'b0, sampleValidR = 1'b0;
  logic [W-1:0] sampleL = '0, sampleR = '0;
  logic muteReqL, muteReqR;

  int checks = 0;
  int errors = 0;
  int runL = 0, runR = 0;
  bit done = 0;

  always #5 clk = ~clk;

  silence_mute_det #(.SAMPLE_W(W), .RUN_LEN(RL)) u0 (
    .clk(clk), .rstN(rstN), .muteEnable(muteEnable),
    .sampleValidL(sampleValidL), .sampleL(sampleL),
    .sampleValidR(sampleValidR), .sampleR(sampleR),
    .muteReqL(muteReqL), .muteReqR(muteReqR)
  );

  function automatic bit silent(logic [W-1:0] v);
    return (v == '0) || (v == '1);
  endfunction

  function automatic int nextRun(int r, bit en, bit vld, logic [W-1:0] v);
    if (!en) return 0;
    if (!vld) return r;
    if (!silent(v)) return 0;
    return (r < RL) ? r + 1 : RL;
  endfunction

  task automatic compare(string tag);
    bit eL, eR;
    eL = (runL == RL);
    eR = (runR == RL);
    checks++;
    if (muteReqL !== eL || muteReqR !== eR) begin
      errors++;
      $display("FAIL %s: muteReqL=%b muteReqR=%b expected %b %b", tag, muteReqL, muteReqR, eL, eR);
    end
  endtask

  // Drive at negedge, let the posedge accept, compare at the next negedge.
  task automatic step(string tag, bit en, bit vL, logic [W-1:0] sL, bit vR, logic [W-1:0] sR);
    muteEnable = en; sampleValidL = vL; sampleL = sL; sampleValidR = vR; sampleR = sR;
    @(posedge clk);
    runL = nextRun(runL, en, vL, sL);
    runR = nextRun(runR, en, vR, sR);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R6: disabled, long silence must not mute
    for (int i = 0; i < 2 * RL; i++) step("R6 disabled", 0, 1, '0, 1, '1);

    // R3/R4: sweep run lengths, each preceded by a non-silent restart
    for (int n = 0; n <= RL + 2; n++) begin
      step("R4 restart", 1, 1, W'(5), 1, W'(7));
      for (int i = 0; i < n; i++) step("R3 run sweep", 1, 1, '0, 1, '0);
    end

    // R9: alternate 0 and all-ones inside one run
    step("R4 restart", 1, 1, W'(3), 1, W'(3));
    for (int i = 0; i < RL + 1; i++) step("R9 mixed silence", 1, 1, (i % 2) ? '1 : '0, 1, (i % 2) ? '0 : '1);

    // R2: every single-bit word and edge values break silence
    for (int b = 0; b < W + 4; b++) begin
      logic [W-1:0] v;
      if (b < W) v = W'(1) << b;
      else if (b == W) v = '1 - W'(1);
      else if (b == W + 1) v = {1'b1, {(W-1){1'b0}}};
      else if (b == W + 2) v = {1'b0, {(W-1){1'b1}}};
      else v = W'(1);
      for (int i = 0; i < RL; i++) step("R2 build", 1, 1, '1, 1, '0);
      step("R2 non-silent release", 1, 1, v, 1, v);
    end

    // R8: idle gaps between valid samples
    step("R4 restart", 1, 1, W'(9), 1, W'(9));
    for (int i = 0; i < RL; i++) begin
      step("R8 valid", 1, 1, '0, 1, '0);
      for (int g = 0; g <= i % 3; g++) step("R8 idle", 1, 0, W'(123), 0, W'(45));
    end

    // R5: right toggles while left completes its run on the same edge
    step("R4 restart", 1, 1, W'(2), 1, W'(2));
    for (int i = 0; i < RL; i++) step("R5 independent", 1, 1, '0, 1, (i == RL - 1) ? W'(77) : '0);
    for (int i = 0; i < RL; i++) step("R5 right only", 1, 0, '0, 1, '1);
    step("R5 left break", 1, 1, W'(11), 0, '0);

    // R7: long silence stays muted
    for (int i = 0; i < 3 * RL; i++) step("R7 saturate", 1, 1, '0, 1, '0);

    // R6: enable drops on the edge a run would complete, and while muted
    step("R4 restart", 1, 1, W'(6), 0, '0);
    for (int i = 0; i < RL - 1; i++) step("R6 prep", 1, 1, '0, 1, '0);
    step("R6 clear wins", 0, 1, '0, 1, '0);
    step("R6 reenable", 1, 1, '0, 1, '0);
    for (int i = 0; i < RL; i++) step("R6 refill", 1, 1, '0, 1, '0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule